// File: doc/BRIEF.md
# EEPROM Checksum Sequencer

This block walks the low words of a word-addressed EEPROM and checks or repairs its integrity word. It sits in front of a memory port that takes single-word read and write requests. The serial protocol behind that port is handled elsewhere. After a start pulse, one of two operations runs. The check operation adds every word from address 0 up to and including the checksum word, using 16-bit wraparound arithmetic. It passes when that total equals the signature 0xBABA. The fix operation adds the words below the checksum word, then writes the signature minus that sum into the checksum word. After a fix, a check of the same contents passes.

The memory port is valid/ready. The block raises `req_valid_o` with the address, the direction and the write data, and holds all of them unchanged until a cycle in which `req_ready_i` is high. That cycle is the handshake. The responder returns `rsp_rdata_i` and `rsp_err_i` in the same cycle. The responder may hold `req_ready_i` low for as many cycles as it needs. Only one request is ever outstanding. Start, mode, busy, done, pass and error are plain level or pulse signals.

Top module: `csum_seq`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, err_o and req_valid_o are all low.
- R2: A check operation reads addresses 0, 1, … up to CSUM_ADDR (default 63) in ascending order. The address advances only on a handshake. While req_valid_o is high and req_ready_i is low, req_valid_o, req_addr_o, req_we_o and req_wdata_o keep their values.
- R3: The words are added with 16-bit wraparound. At the end of a check, pass_o is 1 exactly when the total equals 0xBABA.
- R4: A fix operation (mode_i = 1) reads addresses 0 through CSUM_ADDR−1 in order. It then issues one write (req_we_o = 1) to CSUM_ADDR with data (0xBABA − sum) mod 2^16.
- R5: A read handshake with rsp_err_i = 1 ends the operation at once. done_o then pulses with err_o = 1 and pass_o = 0. No further request is issued.
- R6: A write handshake with rsp_err_i = 1 ends a fix operation with err_o = 1.
- R7: done_o is high for exactly one cycle, the cycle after the final handshake. pass_o is always 0 after a fix operation (mode_i = 0 selects check). pass_o and err_o hold until the next accepted start.
- R8: A start_i pulse while busy_o is high is ignored. It changes neither the sequence, the mode nor the result, and it does not start a new operation afterwards.
- R9: req_valid_o is high only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 1 | 0 = check, 1 = fix; sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Check result (valid with done) |
| err_o | output | 1 | Memory error ended the operation |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted and answered this cycle |
| req_we_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | ADDR_W | Word address |
| req_wdata_o | output | DATA_W | Write data |
| rsp_rdata_i | input | DATA_W | Read data, valid on a read handshake |
| rsp_err_i | input | 1 | Error, valid on a handshake |

## Verification
Two events can land on the same clock edge: a new start request and the final handshake of the running operation. Only the busy flag decides between them. The bench holds start_i high, asking for a fix, for the whole of a check run and releases it in the cycle where done is seen. It then judges that the run still reads all 64 words, passes as a check, issues no write, and that no request appears afterwards. A separate stalled-responder run checks that the request stays stable across wait cycles while the fix result is still computed correctly.

// File: rtl/csum_seq_pkg.sv
package csum_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  typedef enum logic {
    OP_CHECK = 1'b0,
    OP_FIX   = 1'b1
  } seq_op_e;
endpackage

// File: rtl/csum_addr_ctr.sv
module csum_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_o <= '0;
    else if (clr_i) addr_o <= '0;
    else if (inc_i) addr_o <= addr_o + 1'b1;
  end
endmodule

// File: rtl/csum_accum.sv
module csum_accum #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] sum_next_o
);
  // wraparound: carry out of the top bit is dropped
  assign sum_next_o = sum_o + word_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sum_o <= '0;
    else if (clr_i) sum_o <= '0;
    else if (add_i) sum_o <= sum_next_o;
  end
endmodule

// File: rtl/csum_ctrl.sv
module csum_ctrl
  import csum_seq_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CSUM_ADDR = 8'h3F,
  parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              req_ready_i,
  input  logic              rsp_err_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic [DATA_W-1:0] sum_next_i,
  output logic              clr_o,
  output logic              inc_o,
  output logic              add_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              err_o,
  output logic              req_valid_o,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o
);
  localparam logic [ADDR_W-1:0] LAST_FIX_RD =
    (CSUM_ADDR == '0) ? '0 : ADDR_W'(CSUM_ADDR - 1'b1);

  seq_state_e state_q;
  seq_op_e    op_q;
  logic       hs;
  logic       last_rd;
  logic       fix_no_reads;

  generate
    if (CSUM_ADDR == '0) begin : g_empty_body
      assign fix_no_reads = 1'b1;
    end else begin : g_body
      assign fix_no_reads = 1'b0;
    end
  endgenerate

  assign hs      = req_valid_o && req_ready_i;
  assign last_rd = (op_q == OP_FIX) ? (addr_i == LAST_FIX_RD)
                                    : (addr_i == CSUM_ADDR);

  assign busy_o      = (state_q != ST_IDLE);
  assign req_valid_o = busy_o;
  assign req_we_o    = (state_q == ST_WRITE);
  assign req_addr_o  = (state_q == ST_WRITE) ? CSUM_ADDR : addr_i;
  assign req_wdata_o = SIGNATURE - sum_i;

  assign clr_o = (state_q == ST_IDLE) && start_i;
  assign add_o = (state_q == ST_READ) && hs && !rsp_err_i;
  assign inc_o = add_o && !last_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_CHECK;
      done_o  <= 1'b0;
      pass_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q   <= seq_op_e'(mode_i);
            pass_o <= 1'b0;
            err_o  <= 1'b0;
            if (seq_op_e'(mode_i) == OP_FIX && fix_no_reads)
              state_q <= ST_WRITE;
            else
              state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (hs) begin
            if (rsp_err_i) begin
              err_o   <= 1'b1;
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (last_rd) begin
              if (op_q == OP_CHECK) begin
                pass_o  <= (sum_next_i == SIGNATURE);
                done_o  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_WRITE;
              end
            end
          end
        end
        ST_WRITE: begin
          if (hs) begin
            err_o   <= rsp_err_i;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csum_seq.sv
module csum_seq #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CSUM_ADDR = 8'h3F,
  parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              err_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  input  logic              rsp_err_i
);
  logic              ctr_clr, ctr_inc, acc_add;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] sum, sum_next;

  csum_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr_i(ctr_clr), .inc_i(ctr_inc), .addr_o(rd_addr)
  );

  csum_accum #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(ctr_clr), .add_i(acc_add),
    .word_i(rsp_rdata_i), .sum_o(sum), .sum_next_o(sum_next)
  );

  csum_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSUM_ADDR(CSUM_ADDR), .SIGNATURE(SIGNATURE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .req_ready_i(req_ready_i), .rsp_err_i(rsp_err_i),
    .addr_i(rd_addr), .sum_i(sum), .sum_next_i(sum_next),
    .clr_o(ctr_clr), .inc_o(ctr_inc), .add_o(acc_add),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .err_o(err_o),
    .req_valid_o(req_valid_o), .req_we_o(req_we_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o)
  );
endmodule

// File: rtl/csum_seq_chk.sv
module csum_seq_chk #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CSUM_ADDR = 8'h3F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              err_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_we_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_wdata_o,
  input logic              rsp_err_i
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)
      && $stable(req_we_o) && $stable(req_wdata_o)));

  p_addr_on_hs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !(req_valid_o && req_ready_i)) |=> $stable(req_addr_o));

  p_write_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_we_o) |-> (req_addr_o == CSUM_ADDR));

  p_read_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i && !req_we_o && rsp_err_i)
      |=> (!req_valid_o && done_o && err_o && !pass_o));

  p_write_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i && req_we_o && rsp_err_i) |=> (done_o && err_o));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_valid_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> busy_o);
endmodule

bind csum_seq csum_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSUM_ADDR(CSUM_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
  .err_o(err_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_we_o(req_we_o), .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
  .rsp_err_i(rsp_err_i)
);

// File: tb/csum_seq_tb_top.sv
`timescale 1ns/1ps
module csum_seq_tb_top;
  localparam logic [15:0] SIG = 16'hBABA;
  localparam int          NW  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        busy_o, done_o, pass_o, err_o;
  logic        req_valid_o, req_we_o;
  logic        req_ready_i = 1'b0;
  logic [7:0]  req_addr_o;
  logic [15:0] req_wdata_o;
  logic [15:0] rsp_rdata_i = '0;
  logic        rsp_err_i = 1'b0;

  always #2.5 clk = ~clk;

  csum_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .err_o(err_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_we_o(req_we_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
    .rsp_rdata_i(rsp_rdata_i), .rsp_err_i(rsp_err_i)
  );

  logic [15:0] mem [NW];
  int n_checks = 0, n_fail = 0;
  int rd_cnt, wr_cnt, order_bad, proto_bad, err_rd_idx = -1, cyc = 0;
  logic [7:0] exp_addr, wr_addr, p_addr;
  logic stall = 1'b0, wr_err = 1'b0, p_val = 1'b0, p_rdy = 1'b0, p_we = 1'b0;
  logic [15:0] p_wd;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // responder and protocol monitor, all at the falling edge
  always @(negedge clk) begin
    logic rdy;
    cyc++;
    rdy = !stall || (cyc % 3 == 0);
    if (p_val && !p_rdy &&
        (!req_valid_o || req_addr_o != p_addr || req_we_o != p_we || req_wdata_o != p_wd))
      proto_bad++;
    if (req_valid_o && !busy_o) proto_bad++;
    p_val = req_valid_o; p_rdy = rdy; p_addr = req_addr_o; p_we = req_we_o; p_wd = req_wdata_o;
    req_ready_i = rdy;
    rsp_rdata_i = mem[req_addr_o[5:0]];
    rsp_err_i   = 1'b0;
    if (req_valid_o && rdy) begin
      if (!req_we_o) begin
        if (req_addr_o != exp_addr) order_bad++;
        if (rd_cnt == err_rd_idx) rsp_err_i = 1'b1;
        rd_cnt++;
        exp_addr = exp_addr + 1'b1;
      end else begin
        wr_cnt++;
        wr_addr = req_addr_o;
        if (wr_err) rsp_err_i = 1'b1;
        else mem[req_addr_o[5:0]] = req_wdata_o;
      end
    end
  end

  function automatic logic [15:0] sum16(input int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic fill(input logic [15:0] seed);
    for (int i = 0; i < NW; i++) mem[i] = 16'(i * 16'h1357) ^ seed;
  endtask

  task automatic clear_counts();
    rd_cnt = 0; wr_cnt = 0; order_bad = 0; proto_bad = 0; exp_addr = '0;
  endtask

  task automatic run(input logic m, output logic p, output logic e);
    int n = 0;
    clear_counts();
    @(negedge clk); start_i = 1'b1; mode_i = m;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, "R7 done reached", n, 0);
    p = pass_o; e = err_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    chk(pass_o == p && err_o == e, "R7 result held", {pass_o, err_o}, {p, e});
  endtask

  task automatic t_reset();
    chk({busy_o, done_o, pass_o, err_o, req_valid_o} == 5'b0, "R1 reset state",
        {busy_o, done_o, pass_o, err_o, req_valid_o}, 0);
  endtask

  task automatic t_check_good();
    logic p, e;
    fill(16'h0A5C);
    mem[63] = SIG - sum16(63);
    run(1'b0, p, e);
    chk(p == 1'b1 && e == 1'b0, "R3 good image passes", {p, e}, 2);
    chk(rd_cnt == 64, "R2 read count", rd_cnt, 64);
    chk(order_bad == 0, "R2 ascending order", order_bad, 0);
    chk(wr_cnt == 0, "R2 check issues no write", wr_cnt, 0);
    chk(proto_bad == 0, "R9 request protocol", proto_bad, 0);
  endtask

  task automatic t_check_bad();
    logic p, e;
    mem[0] = mem[0] ^ 16'h0001;
    run(1'b0, p, e);
    chk(p == 1'b0 && e == 1'b0, "R3 corrupted image fails", {p, e}, 0);
  endtask

  task automatic t_check_wrap();
    logic p, e;
    for (int i = 0; i < 63; i++) mem[i] = 16'hFFFF;
    mem[63] = SIG - 16'hFFC1;
    run(1'b0, p, e);
    chk(p == 1'b1, "R3 wraparound sum passes", p, 1);
  endtask

  task automatic t_fix_stalled();
    logic p, e;
    logic [15:0] expw;
    fill(16'h7E21);
    mem[63] = 16'h0000;
    expw = SIG - sum16(63);
    stall = 1'b1;
    run(1'b1, p, e);
    stall = 1'b0;
    chk(rd_cnt == 63, "R4 fix reads below checksum", rd_cnt, 63);
    chk(wr_cnt == 1 && wr_addr == 8'h3F, "R4 one write to checksum word", wr_addr, 63);
    chk(mem[63] == expw, "R4 written value", mem[63], expw);
    chk(p == 1'b0 && e == 1'b0, "R7 pass low after fix", {p, e}, 0);
    chk(proto_bad == 0 && order_bad == 0, "R2 stable under back-pressure", proto_bad, 0);
    run(1'b0, p, e);
    chk(p == 1'b1, "R4 fixed image then passes", p, 1);
  endtask

  task automatic t_read_err();
    logic p, e;
    err_rd_idx = 5;
    run(1'b0, p, e);
    chk(e == 1'b1 && p == 1'b0, "R5 read error reported", {p, e}, 1);
    chk(rd_cnt == 6, "R5 abort after failing read", rd_cnt, 6);
    err_rd_idx = 62;
    run(1'b1, p, e);
    chk(e == 1'b1 && wr_cnt == 0, "R5 fix aborts before write", wr_cnt, 0);
    err_rd_idx = -1;
    repeat (5) @(negedge clk);
    chk(rd_cnt == 63 && !busy_o, "R5 no request after abort", rd_cnt, 63);
  endtask

  task automatic t_write_err();
    logic p, e;
    logic [15:0] old;
    old = mem[63];
    wr_err = 1'b1;
    run(1'b1, p, e);
    wr_err = 1'b0;
    chk(e == 1'b1 && wr_cnt == 1, "R6 write error reported", e, 1);
    chk(mem[63] == old, "R6 failed write not stored", mem[63], old);
  endtask

  task automatic t_start_while_busy();
    int n = 0;
    fill(16'h3C3C);
    mem[63] = SIG - sum16(63);
    clear_counts();
    @(negedge clk); start_i = 1'b1; mode_i = 1'b0;
    @(negedge clk); mode_i = 1'b1;
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    start_i = 1'b0;
    chk(pass_o == 1'b1 && err_o == 1'b0, "R8 result unaffected", pass_o, 1);
    chk(wr_cnt == 0 && rd_cnt == 64, "R8 no fix started", wr_cnt, 0);
    repeat (10) @(negedge clk);
    chk(rd_cnt == 64 && !busy_o, "R8 no queued restart", rd_cnt, 64);
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    fill(16'h0000);
    clear_counts();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_check_good();
    t_check_bad();
    t_check_wrap();
    t_fix_stalled();
    t_read_err();
    t_write_err();
    t_start_while_busy();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule